// File: doc/BRIEF.md
# Device Interrupt Status Latch

This block collects sixteen level-sensitive device interrupt lines, brings each through a synchronizer, and records every rising edge in a status register. The status is combined with a per-line mask and a global enable. The result is a 16-bit active vector that a downstream interrupt router consumes.

Software reaches the block through a flat 32-bit register port with a byte offset. Status bits are cleared by writing 1 to them, but a clear is refused while the line that raised the bit is still high. An optional mode clears a bit by itself when its line drops. That mode works only while the `routeMode` strap is high and the auto-clear control bit is set.

The block also holds three plain registers: a firmware segment selector, a firmware read-size selector and an error-address register. They are storage only; nothing inside this block acts on them.

Top module: `irq_latch_top`

## Requirements
- R1: After reset, the segment, control, mask and status registers read 0, the read-size register reads 0x02000000, and `activeVec` is 0.
- R2: The registers sit at these offsets: segment 0x24, read-size 0x28, control 0x30, mask 0x34, status 0x38, error address 0x40. A read of any other offset returns 0xFFFFFFFF.
- R3: Device line n is reported in status bit 31-n. A rising edge of the synchronized line sets that bit. The bit is visible three clock edges after the input changes: two synchronizer flops, then the status flop.
- R4: A write to status clears only the bits that are written as 1 and whose synchronized line is low. Bits whose line is high stay set.
- R5: When `routeMode` is 1 and control bit 23 is 1, a falling edge of the synchronized line clears its status bit. In every other case a falling edge leaves the bit unchanged.
- R6: `activeVec[n]` equals status bit 31-n AND mask bit 31-n while control bit 31 is 1, and is 0 while control bit 31 is 0. It follows register writes in the cycle after the write edge.
- R7: The segment and read-size registers read back the last value written to them. The error-address register reads 0 and ignores writes.
- R8: Status bits 15 down to 0 always read 0, whatever is written to status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| routeMode | input | 1 | Strap that allows the auto-clear mode |
| devIrq | input | 16 | Level-sensitive device interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid in the same cycle as `regRdEn` (0 when not reading) |
| activeVec | output | 16 | Masked and enabled pending interrupts, bit n for line n |

## Verification
The hardest case to reach from the ports is a clear that must be refused. It needs a status bit that is set while its line is still held high, and a write of all ones to status at that moment. The stimulus holds the lines high well past the synchronizer latency before writing, then reads status back. Auto-clear is tested twice with the control bit set: once with `routeMode` low, where a dropping line must not clear its bit, and once with `routeMode` high, where it must.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  localparam int OFF_SEG  = 'h24;
  localparam int OFF_SIZE = 'h28;
  localparam int OFF_CTRL = 'h30;
  localparam int OFF_MASK = 'h34;
  localparam int OFF_STAT = 'h38;
  localparam int OFF_ERR  = 'h40;

  localparam int CTRL_EN_BIT = 31;
  localparam int CTRL_AC_BIT = 23;

  localparam logic [31:0] SIZE_RESET = 32'h0200_0000;

  typedef struct packed {
    logic wrSeg;
    logic wrSize;
    logic wrCtrl;
    logic wrMask;
    logic wrStat;
  } wrStrobe_t;

  typedef enum logic [2:0] {
    SEL_SEG,
    SEL_SIZE,
    SEL_CTRL,
    SEL_MASK,
    SEL_STAT,
    SEL_ERR,
    SEL_NONE
  } rdSel_t;

endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output wrStrobe_t         strb,
  output rdSel_t            rdSel
);

  always_comb begin
    rdSel = SEL_NONE;
    if (regAddr == ADDR_W'(OFF_SEG))       rdSel = SEL_SEG;
    else if (regAddr == ADDR_W'(OFF_SIZE)) rdSel = SEL_SIZE;
    else if (regAddr == ADDR_W'(OFF_CTRL)) rdSel = SEL_CTRL;
    else if (regAddr == ADDR_W'(OFF_MASK)) rdSel = SEL_MASK;
    else if (regAddr == ADDR_W'(OFF_STAT)) rdSel = SEL_STAT;
    else if (regAddr == ADDR_W'(OFF_ERR))  rdSel = SEL_ERR;
  end

  always_comb begin
    strb        = '0;
    strb.wrSeg  = regWrEn && (rdSel == SEL_SEG);
    strb.wrSize = regWrEn && (rdSel == SEL_SIZE);
    strb.wrCtrl = regWrEn && (rdSel == SEL_CTRL);
    strb.wrMask = regWrEn && (rdSel == SEL_MASK);
    strb.wrStat = regWrEn && (rdSel == SEL_STAT);
  end

endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               routeMode,
  input  logic [NUM_IRQ-1:0] devIrq,
  input  wrStrobe_t          strb,
  input  rdSel_t             rdSel,
  input  logic               regRdEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_IRQ-1:0] activeVec
);

  localparam int PAD_W = DATA_W - NUM_IRQ;

  logic [SYNC_STAGES-1:0][NUM_IRQ-1:0] syncStage;
  logic [NUM_IRQ-1:0] syncLvl, prevLvl, riseVec, fallVec;
  logic [NUM_IRQ-1:0] irqStatus, wdMapped, maskPerIrq, clrWrite, clrAuto;
  logic [DATA_W-1:0]  segReg, sizeReg, ctrlReg, maskReg, statusWord;
  logic               autoClrOn;

  // input synchronizer and edge detection
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncStage <= '0;
      prevLvl   <= '0;
    end else begin
      syncStage <= {syncStage[SYNC_STAGES-2:0], devIrq};
      prevLvl   <= syncLvl;
    end
  end

  assign syncLvl = syncStage[SYNC_STAGES-1];
  assign riseVec = syncLvl & ~prevLvl;
  assign fallVec = ~syncLvl & prevLvl;

  // line n lives in word bit DATA_W-1-n
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_map
    assign wdMapped[n]              = regWrData[DATA_W-1-n];
    assign maskPerIrq[n]            = maskReg[DATA_W-1-n];
    assign statusWord[DATA_W-1-n]   = irqStatus[n];
  end
  if (PAD_W > 0) begin : g_pad
    assign statusWord[PAD_W-1:0] = '0;
  end

  assign autoClrOn = routeMode && ctrlReg[CTRL_AC_BIT];
  assign clrWrite  = strb.wrStat ? (wdMapped & ~syncLvl) : '0;
  assign clrAuto   = autoClrOn ? fallVec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqStatus <= '0;
      segReg    <= '0;
      sizeReg   <= SIZE_RESET[DATA_W-1:0];
      ctrlReg   <= '0;
      maskReg   <= '0;
    end else begin
      irqStatus <= (irqStatus & ~clrWrite & ~clrAuto) | riseVec;
      if (strb.wrSeg)  segReg  <= regWrData;
      if (strb.wrSize) sizeReg <= regWrData;
      if (strb.wrCtrl) ctrlReg <= regWrData;
      if (strb.wrMask) maskReg <= regWrData;
    end
  end

  assign activeVec = ctrlReg[CTRL_EN_BIT] ? (irqStatus & maskPerIrq) : '0;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      case (rdSel)
        SEL_SEG:  regRdData = segReg;
        SEL_SIZE: regRdData = sizeReg;
        SEL_CTRL: regRdData = ctrlReg;
        SEL_MASK: regRdData = maskReg;
        SEL_STAT: regRdData = statusWord;
        SEL_ERR:  regRdData = '0;
        default:  regRdData = '1;
      endcase
    end
  end

  // R4
  held_line_not_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrStat |=> ((($past(irqStatus) & $past(syncLvl)) & ~irqStatus) == '0));

  // R3
  set_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (riseVec == '0) |=> ((irqStatus & ~$past(irqStatus)) == '0));

  // R5
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrStat && !autoClrOn) |=> (($past(irqStatus) & ~irqStatus) == '0));

  // R7
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrSize |=> $stable(sizeReg));

endmodule

// File: rtl/irq_latch_top.sv
module irq_latch_top
  import irq_latch_pkg::*;
#(
  parameter int NUM_IRQ     = 16,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               routeMode,
  input  logic [NUM_IRQ-1:0] devIrq,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [NUM_IRQ-1:0] activeVec
);

  wrStrobe_t strb;
  rdSel_t    rdSel;

  irq_latch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb),
    .rdSel   (rdSel)
  );

  irq_latch_dp #(
    .NUM_IRQ     (NUM_IRQ),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .routeMode (routeMode),
    .devIrq    (devIrq),
    .strb      (strb),
    .rdSel     (rdSel),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .activeVec (activeVec)
  );

endmodule

// File: tb/irq_latch_top_bench.sv
`timescale 1ns/1ps
module irq_latch_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        routeMode = 1'b0;
  logic [15:0] devIrq = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] activeVec;
  logic        vecFlag = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          isVec;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  irq_latch_top u_irq_latch_top (
    .clk(clk), .rst_n(rst_n), .routeMode(routeMode), .devIrq(devIrq),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .activeVec(activeVec)
  );

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (regRdEn || vecFlag) begin
      logic [31:0] act;
      item_t it;
      act = vecFlag ? {16'h0, activeVec} : regRdData;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty actual=%h expected=none", act);
      end else begin
        it = q.pop_front();
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    q.push_back('{1'b0, e, req});
    regRdEn = 1'b1; regAddr = a;
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic vecChk(input logic [15:0] e, input string req);
    @(posedge clk); #1;
    q.push_back('{1'b1, {16'h0, e}, req});
    vecFlag = 1'b1;
    @(posedge clk); #1;
    vecFlag = 1'b0;
  endtask

  task automatic setIrq(input int i, input logic v);
    @(posedge clk); #1;
    devIrq[i] = v;
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values
    rdChk(8'h24, 32'h0, "R1 seg");
    rdChk(8'h28, 32'h0200_0000, "R1 size");
    rdChk(8'h30, 32'h0, "R1 ctrl");
    rdChk(8'h34, 32'h0, "R1 mask");
    rdChk(8'h38, 32'h0, "R1 stat");
    vecChk(16'h0, "R1 vec");
    // R2 unmapped offsets
    rdChk(8'h2C, 32'hFFFF_FFFF, "R2 unmapped 0x2C");
    rdChk(8'h00, 32'hFFFF_FFFF, "R2 unmapped 0x00");
    rdChk(8'hFC, 32'hFFFF_FFFF, "R2 unmapped 0xFC");

    // R7 plain registers
    wr(8'h24, 32'h1234_5678);
    wr(8'h28, 32'h0100_0000);
    wr(8'h40, 32'hDEAD_BEEF);
    rdChk(8'h24, 32'h1234_5678, "R7 seg");
    rdChk(8'h28, 32'h0100_0000, "R7 size");
    rdChk(8'h40, 32'h0, "R7 err ignored");

    // R3 latch rising lines 0 and 5
    setIrq(0, 1'b1);
    setIrq(5, 1'b1);
    settle();
    rdChk(8'h38, 32'h8400_0000, "R3 stat");
    vecChk(16'h0, "R6 disabled");

    // R6 mask and enable
    wr(8'h34, 32'h8000_0000);
    wr(8'h30, 32'h8000_0000);
    vecChk(16'h0001, "R6 mask line0");
    wr(8'h34, 32'hFFFF_0000);
    vecChk(16'h0021, "R6 mask all");
    rdChk(8'h34, 32'hFFFF_0000, "R2 mask readback");

    // R4 clear refused while lines held
    wr(8'h38, 32'hFFFF_FFFF);
    rdChk(8'h38, 32'h8400_0000, "R4 held");

    // R5 no auto clear when disabled
    setIrq(0, 1'b0);
    settle();
    rdChk(8'h38, 32'h8400_0000, "R5 no autoclear");
    vecChk(16'h0021, "R6 still pending");

    // R4 clear after drop
    wr(8'h38, 32'h8000_0000);
    rdChk(8'h38, 32'h0400_0000, "R4 cleared");
    vecChk(16'h0020, "R6 after clear");

    // R5 auto clear bit set, routeMode low
    wr(8'h30, 32'h8080_0000);
    setIrq(5, 1'b0);
    settle();
    rdChk(8'h38, 32'h0400_0000, "R5 routeMode low");

    // R5 auto clear active
    routeMode = 1'b1;
    setIrq(3, 1'b1);
    settle();
    rdChk(8'h38, 32'h1400_0000, "R3 line3");
    vecChk(16'h0028, "R6 line3");
    setIrq(3, 1'b0);
    settle();
    rdChk(8'h38, 32'h0400_0000, "R5 autoclear");

    // R8 low bits
    wr(8'h38, 32'h0000_FFFF);
    rdChk(8'h38, 32'h0400_0000, "R8 low bits");
    wr(8'h38, 32'h0400_0000);
    rdChk(8'h38, 32'h0, "R4 clear line5");

    // R6 enable off
    wr(8'h30, 32'h0);
    setIrq(7, 1'b1);
    settle();
    rdChk(8'h38, 32'h0100_0000, "R3 line7");
    vecChk(16'h0, "R6 enable off");
    rdChk(8'h30, 32'h0, "R2 ctrl readback");

    repeat (3) @(posedge clk);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", q.size());
    end
    finishRun();
  end

endmodule